// File: doc/BRIEF.md
# Error Injection Trigger Sequencer

This block walks a short list of programmed error events and decides when each one must be injected into the error status logic of a single strand. Every event has a retired-instruction count threshold and one of three trigger styles. The first fires as soon as the threshold is met. The second waits for a retirement at a given program counter, optionally gated by privilege and trap level. The third waits for the next load or store. When an event fires, the block emits a one-cycle inject pulse that carries the event's error index.

The block serialises injections. After a pulse, no further pulse is issued until the status side reports either that the trap was taken or that no trap will be generated. An event that fires during that window is parked in a pending state. It is injected on the first cycle after the window closes. A persistent event re-arms on the same trigger after it injects. A one-shot event hands over to the next valid entry in the list. When the list is exhausted the block stops until it is restarted.

States: `S_IDLE` (nothing armed), `S_SCAN` (stepping the list pointer to the next valid entry, one entry per cycle), `S_ARMED` (watching the selected entry's trigger) and `S_PENDING` (fired, waiting for the in-flight injection to clear). Transitions:
- start: any state to `S_SCAN` with pointer 0.
- found: `S_SCAN` to `S_ARMED` when the entry is valid.
- skip: `S_SCAN` stays with pointer + 1 when the entry is invalid.
- exhausted: `S_SCAN` to `S_IDLE` at an invalid last entry.
- fire-blocked: `S_ARMED` to `S_PENDING`.
- inject-persistent: to `S_ARMED`.
- inject-advance: to `S_SCAN` with pointer + 1.
- inject-last: to `S_IDLE` after a one-shot last entry.

Top module: `err_inj_sequencer`

## Requirements
- R1: A 32-bit counter counts `retire_vld` strobes and is cleared only by reset. No event fires while the counter value, before the current retirement, is below the event's target.
- R2: Mode encoding is 0 = count only, 1 = program-counter match, 2 = load/store, and 3 = never fires. An armed count-only event fires in the first cycle in which the counter is at or above its target.
- R3: An armed PC event fires on a retirement whose `retire_pc` equals its programmed value, provided the count before that retirement is at or above the target. A retirement at any other PC is ignored.
- R4: An armed load/store event fires on any cycle with `ld_vld` or `st_vld` high once the count is at or above the target.
- R5: A PC event additionally requires `cur_priv` >= the entry's minimum privilege and `cur_tl` <= the entry's maximum trap level. A retirement that fails the qualifier is ignored and a later qualified one still fires.
- R6: An injection appears as `inj_pulse` high for exactly one cycle, one clock edge after the firing cycle, with `inj_err` equal to the entry's error index. It is low after reset.
- R7: After a pulse, no further pulse occurs until `trap_taken` or `no_trap` is sampled high.
- R8: An event that fires during an in-flight injection is held. It is injected with its pulse visible after the second clock edge following the acknowledge.
- R9: After injecting, a persistent entry re-arms the same trigger. A one-shot entry advances to the next valid entry, and invalid entries are skipped at one per cycle.
- R10: When no valid entry remains after the pointer, the block goes idle and ignores all strobes until `arm_start`.
- R11: `no_trap` releases the in-flight injection exactly as `trap_taken` does.
- R12: `cfg_we` writes the entry at `cfg_addr`. Reset invalidates all entries. `arm_start` restarts the walk from entry 0 without clearing the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_addr | input | 3 | Entry index to write |
| cfg_valid | input | 1 | Entry valid bit |
| cfg_persist | input | 1 | Re-arm after injection |
| cfg_mode | input | 2 | Trigger style (see R2) |
| cfg_target | input | 32 | Instruction count threshold |
| cfg_pc | input | 32 | Program counter to match |
| cfg_err | input | 6 | Error index reported on injection |
| cfg_min_priv | input | 2 | Minimum privilege for a PC trigger |
| cfg_max_tl | input | 3 | Maximum trap level for a PC trigger |
| arm_start | input | 1 | Restart the list walk at entry 0 |
| retire_vld | input | 1 | One instruction retired |
| retire_pc | input | 32 | PC of the retired instruction |
| ld_vld | input | 1 | Load executed |
| st_vld | input | 1 | Store executed |
| cur_priv | input | 2 | Current privilege level |
| cur_tl | input | 3 | Current trap level |
| trap_taken | input | 1 | The injected trap was taken |
| no_trap | input | 1 | The injected error produced no trap |
| inj_pulse | output | 1 | Injection request, one cycle |
| inj_err | output | 6 | Error index of the injection |

## Verification
The embedded properties check the cycle-level contract on every clock:
- a pulse never follows a cycle with an injection in flight;
- pulses never come back to back;
- either acknowledge releases the in-flight flag;
- pending and idle states never produce a pulse;
- the counter steps by one per retirement.

Only the bench's scenarios can show the rest:
- which entry fires and with which error index;
- that PC mismatches and failed qualifiers are ignored;
- that invalid entries are skipped;
- the exact latency of a held event after its acknowledge;
- that a restart re-arms the list.

// File: rtl/einj_pkg.sv
package einj_pkg;

    typedef enum logic [1:0] {
        TM_COUNT = 2'd0,
        TM_PC    = 2'd1,
        TM_LDST  = 2'd2,
        TM_OFF   = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_SCAN    = 2'd1,
        S_ARMED   = 2'd2,
        S_PENDING = 2'd3
    } seq_state_e;

endpackage

// File: rtl/einj_icount.sv
module einj_icount #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> cnt == $past(cnt) + CNT_W'(1)); // R1

endmodule

// File: rtl/einj_evt_table.sv
module einj_evt_table #(
    parameter int N      = 8,
    parameter int IDX_W  = 3,
    parameter int CNT_W  = 32,
    parameter int PC_W   = 32,
    parameter int ERR_W  = 6,
    parameter int PRIV_W = 2,
    parameter int TL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_persist,
    input  logic [1:0]        wr_mode,
    input  logic [CNT_W-1:0]  wr_target,
    input  logic [PC_W-1:0]   wr_pc,
    input  logic [ERR_W-1:0]  wr_err,
    input  logic [PRIV_W-1:0] wr_min_priv,
    input  logic [TL_W-1:0]   wr_max_tl,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic              rd_persist,
    output logic [1:0]        rd_mode,
    output logic [CNT_W-1:0]  rd_target,
    output logic [PC_W-1:0]   rd_pc,
    output logic [ERR_W-1:0]  rd_err,
    output logic [PRIV_W-1:0] rd_min_priv,
    output logic [TL_W-1:0]   rd_max_tl
);

    typedef struct packed {
        logic              valid;
        logic              persist;
        logic [1:0]        mode;
        logic [CNT_W-1:0]  target;
        logic [PC_W-1:0]   pc;
        logic [ERR_W-1:0]  err;
        logic [PRIV_W-1:0] min_priv;
        logic [TL_W-1:0]   max_tl;
    } entry_t;

    entry_t ent [N];
    entry_t wr_word;
    entry_t rd_word;

    always_comb begin
        wr_word.valid    = wr_valid;
        wr_word.persist  = wr_persist;
        wr_word.mode     = wr_mode;
        wr_word.target   = wr_target;
        wr_word.pc       = wr_pc;
        wr_word.err      = wr_err;
        wr_word.min_priv = wr_min_priv;
        wr_word.max_tl   = wr_max_tl;
    end

    for (genvar g = 0; g < N; g++) begin : g_entry
        entry_t slot_q;
        logic   hit;

        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (hit) begin
                slot_q <= wr_word;
            end
        end

        assign ent[g] = slot_q;
    end

    assign rd_word     = ent[rd_idx];
    assign rd_valid    = rd_word.valid;
    assign rd_persist  = rd_word.persist;
    assign rd_mode     = rd_word.mode;
    assign rd_target   = rd_word.target;
    assign rd_pc       = rd_word.pc;
    assign rd_err      = rd_word.err;
    assign rd_min_priv = rd_word.min_priv;
    assign rd_max_tl   = rd_word.max_tl;

endmodule

// File: rtl/einj_trig_eval.sv
module einj_trig_eval
    import einj_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PC_W   = 32,
    parameter int PRIV_W = 2,
    parameter int TL_W   = 3
) (
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  target,
    input  logic [PC_W-1:0]   match_pc,
    input  logic [PRIV_W-1:0] min_priv,
    input  logic [TL_W-1:0]   max_tl,
    input  logic [CNT_W-1:0]  icnt,
    input  logic              retire_vld,
    input  logic [PC_W-1:0]   retire_pc,
    input  logic              ld_vld,
    input  logic              st_vld,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic [TL_W-1:0]   cur_tl,
    output logic              fire
);

    logic count_met;
    logic level_ok;
    logic pc_hit;

    always_comb begin
        count_met = (icnt >= target);
        level_ok  = (cur_priv >= min_priv) && (cur_tl <= max_tl);
        pc_hit    = retire_vld && (retire_pc == match_pc);
        unique case (trig_mode_e'(mode))
            TM_COUNT: fire = count_met;
            TM_PC:    fire = count_met && pc_hit && level_ok;
            TM_LDST:  fire = count_met && (ld_vld || st_vld);
            default:  fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/err_inj_sequencer.sv
module err_inj_sequencer
    import einj_pkg::*;
#(
    parameter int N_EVT  = 8,
    parameter int CNT_W  = 32,
    parameter int PC_W   = 32,
    parameter int ERR_W  = 6,
    parameter int PRIV_W = 2,
    parameter int TL_W   = 3,
    parameter int IDX_W  = (N_EVT > 1) ? $clog2(N_EVT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_addr,
    input  logic              cfg_valid,
    input  logic              cfg_persist,
    input  logic [1:0]        cfg_mode,
    input  logic [CNT_W-1:0]  cfg_target,
    input  logic [PC_W-1:0]   cfg_pc,
    input  logic [ERR_W-1:0]  cfg_err,
    input  logic [PRIV_W-1:0] cfg_min_priv,
    input  logic [TL_W-1:0]   cfg_max_tl,
    input  logic              arm_start,
    input  logic              retire_vld,
    input  logic [PC_W-1:0]   retire_pc,
    input  logic              ld_vld,
    input  logic              st_vld,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic [TL_W-1:0]   cur_tl,
    input  logic              trap_taken,
    input  logic              no_trap,
    output logic              inj_pulse,
    output logic [ERR_W-1:0]  inj_err
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_EVT - 1);

    seq_state_e        state_q, state_d;
    logic [IDX_W-1:0]  ptr_q, ptr_d;
    logic              inflight_q;
    logic              do_inject;
    logic              fire;
    logic              release_ack;

    logic [CNT_W-1:0]  icnt;
    logic              ev_valid;
    logic              ev_persist;
    logic [1:0]        ev_mode;
    logic [CNT_W-1:0]  ev_target;
    logic [PC_W-1:0]   ev_pc;
    logic [ERR_W-1:0]  ev_err;
    logic [PRIV_W-1:0] ev_min_priv;
    logic [TL_W-1:0]   ev_max_tl;

    einj_icount #(.CNT_W(CNT_W)) u_icount (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (retire_vld),
        .cnt   (icnt)
    );

    einj_evt_table #(
        .N(N_EVT), .IDX_W(IDX_W), .CNT_W(CNT_W), .PC_W(PC_W),
        .ERR_W(ERR_W), .PRIV_W(PRIV_W), .TL_W(TL_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_we),
        .wr_idx      (cfg_addr),
        .wr_valid    (cfg_valid),
        .wr_persist  (cfg_persist),
        .wr_mode     (cfg_mode),
        .wr_target   (cfg_target),
        .wr_pc       (cfg_pc),
        .wr_err      (cfg_err),
        .wr_min_priv (cfg_min_priv),
        .wr_max_tl   (cfg_max_tl),
        .rd_idx      (ptr_q),
        .rd_valid    (ev_valid),
        .rd_persist  (ev_persist),
        .rd_mode     (ev_mode),
        .rd_target   (ev_target),
        .rd_pc       (ev_pc),
        .rd_err      (ev_err),
        .rd_min_priv (ev_min_priv),
        .rd_max_tl   (ev_max_tl)
    );

    einj_trig_eval #(
        .CNT_W(CNT_W), .PC_W(PC_W), .PRIV_W(PRIV_W), .TL_W(TL_W)
    ) u_trig (
        .mode       (ev_mode),
        .target     (ev_target),
        .match_pc   (ev_pc),
        .min_priv   (ev_min_priv),
        .max_tl     (ev_max_tl),
        .icnt       (icnt),
        .retire_vld (retire_vld),
        .retire_pc  (retire_pc),
        .ld_vld     (ld_vld),
        .st_vld     (st_vld),
        .cur_priv   (cur_priv),
        .cur_tl     (cur_tl),
        .fire       (fire)
    );

    assign release_ack = trap_taken || no_trap;

    // Next-state decision
    always_comb begin
        state_d   = state_q;
        ptr_d     = ptr_q;
        do_inject = 1'b0;
        if (arm_start) begin
            state_d = S_SCAN;
            ptr_d   = '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    state_d = S_IDLE;
                end
                S_SCAN: begin
                    if (ev_valid) begin
                        state_d = S_ARMED;
                    end else if (ptr_q == LAST_IDX) begin
                        state_d = S_IDLE;
                    end else begin
                        ptr_d = ptr_q + IDX_W'(1);
                    end
                end
                S_ARMED: begin
                    if (fire) begin
                        if (!inflight_q) begin
                            do_inject = 1'b1;
                        end else begin
                            state_d = S_PENDING;
                        end
                    end
                end
                S_PENDING: begin
                    if (!inflight_q) begin
                        do_inject = 1'b1;
                    end
                end
                default: begin
                    state_d = S_IDLE;
                end
            endcase
            if (do_inject) begin
                if (ev_persist) begin
                    state_d = S_ARMED;
                end else if (ptr_q == LAST_IDX) begin
                    state_d = S_IDLE;
                end else begin
                    state_d = S_SCAN;
                    ptr_d   = ptr_q + IDX_W'(1);
                end
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            ptr_q      <= '0;
            inflight_q <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            if (do_inject) begin
                inflight_q <= 1'b1;
            end else if (release_ack) begin
                inflight_q <= 1'b0;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_pulse <= 1'b0;
            inj_err   <= '0;
        end else begin
            inj_pulse <= do_inject;
            if (do_inject) begin
                inj_err <= ev_err;
            end
        end
    end

    AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        inj_pulse |-> !$past(inflight_q)); // R7

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        inj_pulse |=> !inj_pulse); // R6

    AST_TAKEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight_q && trap_taken) |=> !inflight_q); // R7

    AST_NOTRAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight_q && no_trap) |=> !inflight_q); // R11

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PENDING && inflight_q) |=> !inj_pulse); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !inj_pulse); // R10

endmodule

// File: tb/err_inj_sequencer_tb.sv
`timescale 1ns/1ps
module err_inj_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic        cfg_valid;
    logic        cfg_persist;
    logic [1:0]  cfg_mode;
    logic [31:0] cfg_target;
    logic [31:0] cfg_pc;
    logic [5:0]  cfg_err;
    logic [1:0]  cfg_min_priv;
    logic [2:0]  cfg_max_tl;
    logic        arm_start;
    logic        retire_vld;
    logic [31:0] retire_pc;
    logic        ld_vld;
    logic        st_vld;
    logic [1:0]  cur_priv;
    logic [2:0]  cur_tl;
    logic        trap_taken;
    logic        no_trap;
    logic        inj_pulse;
    logic [5:0]  inj_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    err_inj_sequencer dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_valid(cfg_valid),
        .cfg_persist(cfg_persist), .cfg_mode(cfg_mode), .cfg_target(cfg_target),
        .cfg_pc(cfg_pc), .cfg_err(cfg_err), .cfg_min_priv(cfg_min_priv),
        .cfg_max_tl(cfg_max_tl), .arm_start(arm_start),
        .retire_vld(retire_vld), .retire_pc(retire_pc),
        .ld_vld(ld_vld), .st_vld(st_vld), .cur_priv(cur_priv), .cur_tl(cur_tl),
        .trap_taken(trap_taken), .no_trap(no_trap),
        .inj_pulse(inj_pulse), .inj_err(inj_err)
    );

    // {retire, pc[15:0], ld, st, taken, notrap, exp_pulse, exp_err[5:0]}
    localparam int NV = 15;
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 16'h0100, 4'b0000, 1'b0, 6'd0},  // R1 count 0 below target
        {1'b1, 16'h0100, 4'b0000, 1'b0, 6'd0},  // R1 count 1
        {1'b1, 16'h0104, 4'b0000, 1'b0, 6'd0},  // R1 count 2
        {1'b1, 16'h0104, 4'b0000, 1'b0, 6'd0},  // R3 count met, pc differs
        {1'b1, 16'h0100, 4'b0000, 1'b1, 6'd5},  // R3 R6 fire entry 0
        {1'b0, 16'h0000, 4'b0000, 1'b0, 6'd0},  // R9 skip invalid entry 1
        {1'b0, 16'h0000, 4'b1000, 1'b0, 6'd0},  // R9 load while still scanning
        {1'b0, 16'h0000, 4'b0100, 1'b0, 6'd0},  // R4 R7 fires but blocked
        {1'b0, 16'h0000, 4'b0000, 1'b0, 6'd0},  // R8 held
        {1'b0, 16'h0000, 4'b0010, 1'b0, 6'd0},  // R8 taken sampled
        {1'b0, 16'h0000, 4'b0000, 1'b1, 6'd9},  // R8 released inject
        {1'b0, 16'h0000, 4'b1000, 1'b0, 6'd0},  // R9 persistent re-fire blocked
        {1'b0, 16'h0000, 4'b0001, 1'b0, 6'd0},  // R11 no-trap sampled
        {1'b0, 16'h0000, 4'b0000, 1'b1, 6'd9},  // R11 released inject
        {1'b0, 16'h0000, 4'b0000, 1'b0, 6'd0}   // R4 no strobe, no fire
    };

    task automatic apply(input logic r, input logic [31:0] pc, input logic l,
                         input logic s, input logic t, input logic n,
                         input logic go, input logic [1:0] pv, input logic [2:0] tl);
        retire_vld = r;  retire_pc = pc; ld_vld = l; st_vld = s;
        trap_taken = t;  no_trap = n;    arm_start = go;
        cur_priv = pv;   cur_tl = tl;
        @(negedge clk);
    endtask

    task automatic idle();
        apply(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0);
    endtask

    task automatic chk(input string tag, input logic ep, input logic [5:0] ee);
        n_checks++;
        if (inj_pulse !== ep || (ep && inj_err !== ee)) begin
            n_fails++;
            $display("FAIL %s: pulse=%0b err=%0d expected pulse=%0b err=%0d",
                     tag, inj_pulse, inj_err, ep, ee);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic v, input logic p,
                             input logic [1:0] m, input logic [31:0] tg,
                             input logic [31:0] pc, input logic [5:0] e,
                             input logic [1:0] mp, input logic [2:0] mt);
        cfg_addr = a; cfg_valid = v; cfg_persist = p; cfg_mode = m;
        cfg_target = tg; cfg_pc = pc; cfg_err = e; cfg_min_priv = mp; cfg_max_tl = mt;
        cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        idle();
        rst_n = 1'b1;
    endtask

    initial begin
        cfg_we = 1'b0; cfg_addr = '0; cfg_valid = 1'b0; cfg_persist = 1'b0;
        cfg_mode = '0; cfg_target = '0; cfg_pc = '0; cfg_err = '0;
        cfg_min_priv = '0; cfg_max_tl = '0;
        rst_n = 1'b0;
        @(negedge clk);
        do_reset();
        chk("R6 reset state", 1'b0, 6'd0);

        // Table walk: entry 0 PC one-shot, entry 1 invalid, entry 2 load/store persistent
        cfg_write(3'd0, 1'b1, 1'b0, 2'd1, 32'd3, 32'h100, 6'd5, 2'd0, 3'd7);
        cfg_write(3'd2, 1'b1, 1'b1, 2'd2, 32'd0, 32'h0,   6'd9, 2'd0, 3'd7);
        apply(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0);
        idle();
        idle();
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][27], {16'h0, VEC[i][26:11]}, VEC[i][10], VEC[i][9],
                  VEC[i][8], VEC[i][7], 1'b0, 2'd0, 3'd0);
            chk($sformatf("vector %0d (R1 R3 R4 R6 R7 R8 R9 R11)", i),
                VEC[i][6], VEC[i][5:0]);
        end

        // Count-only event on last entry, then exhaustion
        do_reset();
        cfg_write(3'd7, 1'b1, 1'b0, 2'd0, 32'd2, 32'h0, 6'd33, 2'd0, 3'd0);
        apply(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0);
        for (int i = 0; i < 10; i++) begin
            idle();
            chk("R1 count zero below target", 1'b0, 6'd0);
        end
        apply(1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0);
        chk("R1 first retire", 1'b0, 6'd0);
        apply(1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 3'd0);
        chk("R1 second retire", 1'b0, 6'd0);
        idle();
        chk("R2 count-only fires", 1'b1, 6'd33);
        apply(1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 3'd0);
        chk("R10 after last entry", 1'b0, 6'd0);
        for (int i = 0; i < 5; i++) begin
            apply(1'b1, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 3'd0);
            chk("R10 idle ignores strobes", 1'b0, 6'd0);
        end

        // Qualified PC event, no-trap release, restart
        do_reset();
        cfg_write(3'd0, 1'b1, 1'b0, 2'd1, 32'd0, 32'h40, 6'd12, 2'd2, 3'd1);
        apply(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0);
        idle();
        idle();
        apply(1'b1, 32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 3'd0);
        chk("R5 privilege too low", 1'b0, 6'd0);
        apply(1'b1, 32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 3'd2);
        chk("R5 trap level too high", 1'b0, 6'd0);
        apply(1'b1, 32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 3'd1);
        chk("R5 qualified fire", 1'b1, 6'd12);
        apply(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 3'd0);
        chk("R11 no-trap cycle", 1'b0, 6'd0);
        apply(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 3'd0);
        chk("R12 restart cycle", 1'b0, 6'd0);
        idle();
        idle();
        apply(1'b1, 32'h40, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 3'd0);
        chk("R12 R11 re-armed after restart", 1'b1, 6'd12);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

endmodule